// File: doc/BRIEF.md
# Horizontal Span Fill Pixel Filter

This block is a streaming filter placed between the stage that produces colour indices and the colour lookup. While its mode bit is set, each pixel with colour index zero is replaced by the most recent non-zero index seen earlier on the same raster line. A vector renderer can therefore draw only the outline edges of a polygon and let the hardware fill the span between them.

Pixels arrive one per cycle when `pix_vld` is high, and `pix_sol` marks the first pixel of a line. The output is one register stage behind the input. That delay is the same whether the fill is on or off. The index width is a parameter, and 4-bit and 8-bit indices are supported.

Top module: `span_fill`

## Requirements
- R1: While reset is asserted, and after it is released, `out_vld` is 0 and `out_idx` is 0 until the first valid pixel.
- R2: `out_vld` is high exactly in the cycle after a cycle with `pix_vld` high.
- R3: With `fill_en` low, the `out_idx` that follows a valid pixel equals that pixel's index.
- R4: With `fill_en` high, a valid pixel with a non-zero index is output unchanged.
- R5: With `fill_en` high, a valid zero pixel is output as the last non-zero index seen earlier on the current line, across any number of consecutive zeros.
- R6: A valid pixel with `pix_sol` high clears the held colour before it is used, so zero pixels at the start of a line output index 0.
- R7: Cycles with `pix_vld` low change neither the held colour nor `out_idx`, and `pix_sol` has no effect in such cycles.
- R8: A line-start pixel with a non-zero index is output as itself and becomes the held colour.
- R9: The full index range passes through, including the all-ones value (255 for the default `IDX_W` = 8). `IDX_W` values other than 4 and 8 are rejected at elaboration.
- R10: The held colour follows valid non-zero pixels even while `fill_en` is low, so enabling the fill in the middle of a line uses the last non-zero index seen on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fill_en | input | 1 | Span fill mode bit |
| pix_vld | input | 1 | Input pixel valid |
| pix_sol | input | 1 | Marks the first pixel of a line; only acts together with `pix_vld` |
| pix_idx | input | IDX_W | Input colour index |
| out_vld | output | 1 | Output pixel valid |
| out_idx | output | IDX_W | Output colour index |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid delay;
- exact pass-through when the fill is off;
- that non-zero pixels are untouched when the fill is on;
- that a zero pixel at line start comes out as index 0;
- that `out_idx` is stable across stalls.

Some behaviours depend on the history of a line and are shown only by the bench's scenarios:
- the inherited colour across runs of zeros;
- the held colour surviving stalls and ignored line-start marks;
- the held colour tracking pixels while the fill is disabled;
- clearing of the held colour by a reset in the middle of a stream.

// File: rtl/span_fill_pkg.sv
package span_fill_pkg;

  localparam int unsigned NARROW_W = 4;
  localparam int unsigned WIDE_W   = 8;

  function automatic bit width_ok(int unsigned w);
    return (w == NARROW_W) || (w == WIDE_W);
  endfunction

endpackage

// File: rtl/span_fill_rst_sync.sv
module span_fill_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST:0], 1'b1};
    chain_d = chain_d[LAST:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/span_fill_hold.sv
module span_fill_hold #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic             pix_sol,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [IDX_W-1:0] eff_hold
);
  logic [IDX_W-1:0] hold_q;
  logic [IDX_W-1:0] hold_d;
  logic             hold_ce;

  always_comb begin
    eff_hold = pix_sol ? '0 : hold_q;
    hold_d   = (pix_idx != '0) ? pix_idx : eff_hold;
    hold_ce  = pix_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_ce) hold_q <= hold_d;
  end
endmodule

// File: rtl/span_fill_pick.sv
module span_fill_pick #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             fill_en,
  input  logic [IDX_W-1:0] pix_idx,
  input  logic [IDX_W-1:0] eff_hold,
  output logic [IDX_W-1:0] pick_idx
);
  logic is_zero;

  always_comb begin
    is_zero  = (pix_idx == '0);
    pick_idx = (fill_en && is_zero) ? eff_hold : pix_idx;
  end
endmodule

// File: rtl/span_fill.sv
module span_fill
  import span_fill_pkg::*;
#(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic             pix_vld,
  input  logic             pix_sol,
  input  logic [IDX_W-1:0] pix_idx,
  output logic             out_vld,
  output logic [IDX_W-1:0] out_idx
);
  // R9: only the supported index widths elaborate
  generate
    if (!width_ok(IDX_W)) begin : g_bad_width
      $error("span_fill: IDX_W must be 4 or 8");
    end
  endgenerate

  logic             rst_q_n;
  logic [IDX_W-1:0] eff_hold;
  logic [IDX_W-1:0] pick_idx;
  logic             vld_d;
  logic [IDX_W-1:0] idx_d;
  logic             idx_ce;

  span_fill_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  span_fill_hold #(.IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_q_n), .pix_vld(pix_vld), .pix_sol(pix_sol),
    .pix_idx(pix_idx), .eff_hold(eff_hold)
  );

  span_fill_pick #(.IDX_W(IDX_W)) u_pick (
    .fill_en(fill_en), .pix_idx(pix_idx), .eff_hold(eff_hold),
    .pick_idx(pick_idx)
  );

  always_comb begin
    vld_d  = pix_vld;
    idx_ce = pix_vld;
    idx_d  = pick_idx;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_vld <= 1'b0;
      out_idx <= '0;
    end else begin
      out_vld <= vld_d;
      if (idx_ce) out_idx <= idx_d;
    end
  end
endmodule

// File: rtl/span_fill_chk.sv
module span_fill_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             fill_en,
  input logic             pix_vld,
  input logic             pix_sol,
  input logic [IDX_W-1:0] pix_idx,
  input logic             out_vld,
  input logic [IDX_W-1:0] out_idx
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    pix_vld |=> out_vld);
  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pix_vld |=> !out_vld);
  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pix_vld && !fill_en) |=> (out_idx == $past(pix_idx)));
  // R4
  nonzero_pass_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pix_vld && fill_en && pix_idx != '0) |=> (out_idx == $past(pix_idx)));
  // R6
  sol_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pix_vld && fill_en && pix_sol && pix_idx == '0) |=> (out_idx == '0));
  // R7
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pix_vld |=> $stable(out_idx));
endmodule

bind span_fill span_fill_chk #(.IDX_W(IDX_W)) u_span_fill_chk (
  .clk(clk), .rst_q_n(rst_q_n), .fill_en(fill_en), .pix_vld(pix_vld),
  .pix_sol(pix_sol), .pix_idx(pix_idx), .out_vld(out_vld), .out_idx(out_idx)
);

// File: tb/span_fill_bench.sv
module span_fill_bench;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned NV    = 18;

  // {fill_en, sol, vld, idx[7:0], exp_vld, exp_idx[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1,8'd0,   1'b1,8'd0},   // R6 leading zero
    {1'b1,1'b0,1'b1,8'd0,   1'b1,8'd0},   // R6
    {1'b1,1'b0,1'b1,8'd5,   1'b1,8'd5},   // R4
    {1'b1,1'b0,1'b1,8'd0,   1'b1,8'd5},   // R5
    {1'b1,1'b0,1'b1,8'd0,   1'b1,8'd5},   // R5 run
    {1'b1,1'b0,1'b0,8'd9,   1'b0,8'd5},   // R7 stall
    {1'b1,1'b0,1'b1,8'd0,   1'b1,8'd5},   // R7 hold kept
    {1'b1,1'b0,1'b1,8'd3,   1'b1,8'd3},   // R4
    {1'b1,1'b0,1'b1,8'd0,   1'b1,8'd3},   // R5
    {1'b0,1'b0,1'b1,8'd0,   1'b1,8'd0},   // R3
    {1'b0,1'b0,1'b1,8'd7,   1'b1,8'd7},   // R3
    {1'b1,1'b0,1'b1,8'd0,   1'b1,8'd7},   // R10
    {1'b1,1'b1,1'b1,8'd0,   1'b1,8'd0},   // R6 new line
    {1'b1,1'b1,1'b1,8'd200, 1'b1,8'd200}, // R8
    {1'b1,1'b0,1'b1,8'd0,   1'b1,8'd200}, // R8
    {1'b1,1'b0,1'b1,8'd255, 1'b1,8'd255}, // R9
    {1'b1,1'b1,1'b0,8'd0,   1'b0,8'd255}, // R7 sol ignored
    {1'b1,1'b0,1'b1,8'd0,   1'b1,8'd255}  // R7
  };

  logic             clk;
  logic             rst_n;
  logic             fill_en;
  logic             pix_vld;
  logic             pix_sol;
  logic [IDX_W-1:0] pix_idx;
  logic             out_vld;
  logic [IDX_W-1:0] out_idx;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  span_fill #(.IDX_W(IDX_W)) u_span_fill (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .pix_vld(pix_vld),
    .pix_sol(pix_sol), .pix_idx(pix_idx), .out_vld(out_vld), .out_idx(out_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, logic ev, logic [IDX_W-1:0] ei);
    checks++;
    if (out_vld !== ev || out_idx !== ei) begin
      failures++;
      $display("FAIL %s: got vld=%0d idx=%0d expected vld=%0d idx=%0d",
               req, out_vld, out_idx, ev, ei);
    end
  endtask

  task automatic drive(logic en, logic sol, logic vld, logic [IDX_W-1:0] idx);
    fill_en = en; pix_sol = sol; pix_vld = vld; pix_idx = idx;
  endtask

  initial begin
    drive(1'b0, 1'b0, 1'b0, '0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      @(negedge clk);
      check($sformatf("vector %0d", i), VEC[i][8], VEC[i][7:0]);
    end

    // R1: reset mid-stream clears output and held colour
    drive(1'b1, 1'b0, 1'b1, 8'd44);
    @(negedge clk);
    check("R4 before reset", 1'b1, 8'd44);
    drive(1'b1, 1'b0, 1'b0, '0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", 1'b0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 8'd0);
    @(negedge clk);
    check("R1 hold cleared", 1'b1, 8'd0);

    // R5: long zero run
    drive(1'b1, 1'b0, 1'b1, 8'd17);
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      drive(1'b1, 1'b0, 1'b1, 8'd0);
      @(negedge clk);
      check("R5 long run", 1'b1, 8'd17);
    end
    drive(1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R2 idle", 1'b0, 8'd17);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule